// File: doc/BRIEF.md
# Sharer-Vector Sharing-Matrix Row Updater

This block turns one page-usage report into updates of a pairwise sharing matrix held in memory. A report names the thread that has just finished using a page and says whether its access count for that page reached the page's threshold. It arrives together with the page's short history of recent sharer threads. For a qualifying report, the block walks the history one slot at a time. For every slot that holds another thread, it reads the matrix word at row T and the column of that sharer, adds one (saturating), and writes the word back. It then returns the history with T pushed in at the newest position and the oldest entry dropped.

The matrix is a square array of 32-bit words starting at a base address. Its side length is the dimension value. Both come from configuration inputs that system software sets. The block touches only the row of the reporting thread, so each thread's row is written only on its own behalf. The memory side is a single-outstanding request port with a valid/ready handshake and a separate read-response strobe. A report that does not qualify produces no memory traffic and returns the history unchanged.

Top module: `sharer_matrix_upd`

## Requirements
- R1: A report accepted with `rptQualified` low issues no memory request and returns `svOut`/`svValidOut` equal to the vector it received.
- R2: For a qualifying report, each eligible slot gets exactly one read followed by one write of the same word, and slots are visited in order from slot 0 (newest) to slot SLOTS-1 (oldest).
- R3: The word for sharer column c of thread T is at `cfgBase + (T*cfgDim + c)*4`. No request falls outside row T.
- R4: The written value is the read value plus one, except that a word already at all ones (0xFFFFFFFF) is written back unchanged.
- R5: After the updates, `svOutValid` pulses for exactly one cycle. For a qualifying report, slot 0 of `svOut` holds T with its valid bit set, slot k holds the incoming slot k-1 with its valid bit, and the incoming oldest slot is dropped. Slot k occupies bits `[k*THREAD_W +: THREAD_W]`.
- R6: A slot whose valid bit is 0 or whose ID equals T causes no memory request.
- R7: `rptReady` is high only while the block is idle. A report is taken in the cycle `rptValid` and `rptReady` are both high.
- R8: While `memReqValid` is high and `memReqReady` is low, the request stays valid and its address, direction and data do not change.
- R9: After reset, `rptReady` is 1 and both `memReqValid` and `svOutValid` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| rptValid | input | 1 | Report offered |
| rptReady | output | 1 | Block idle and taking a report |
| rptThread | input | THREAD_W | Reporting thread T |
| rptQualified | input | 1 | Access count reached the page threshold |
| svIn | input | SLOTS*THREAD_W | Incoming sharer IDs, slot 0 newest |
| svValidIn | input | SLOTS | Valid bit per incoming slot |
| cfgBase | input | ADDR_W | Byte address of matrix element (0,0) |
| cfgDim | input | THREAD_W+1 | Matrix side length |
| memReqValid | output | 1 | Memory request valid |
| memReqReady | input | 1 | Memory accepts the request |
| memReqWrite | output | 1 | 1 for write, 0 for read |
| memReqAddr | output | ADDR_W | Request byte address |
| memReqWdata | output | DATA_W | Write data |
| memRspValid | input | 1 | Read data valid |
| memRspData | input | DATA_W | Read data |
| svOutValid | output | 1 | Updated sharer vector valid, one cycle |
| svOut | output | SLOTS*THREAD_W | Updated sharer IDs |
| svValidOut | output | SLOTS | Updated valid bits |

## Verification
The bench builds the block with 3-bit thread IDs, four slots and a matrix dimension of 8. This gives a 64-word memory model in which every row and column can be reached, and random histories hit duplicate sharers, self-entries and empty slots often. The memory model stalls at random and varies the read latency from one to three cycles, which exercises request holding. It also preloads a word next to all ones so that the saturation edge is crossed within two reports.

// File: rtl/smu_pkg.sv
package smu_pkg;
  typedef struct packed {
    logic load;
    logic capRd;
    logic advance;
  } ctlStrobe_t;

  typedef struct packed {
    logic eligible;
    logic lastSlot;
  } dpStatus_t;

  typedef enum logic [2:0] {
    ST_IDLE, ST_SCAN, ST_RD_REQ, ST_RD_WAIT, ST_WR_REQ, ST_WB
  } ctlState_t;
endpackage

// File: rtl/smu_datapath.sv
module smu_datapath
  import smu_pkg::*;
#(
  parameter int THREAD_W = 6,
  parameter int SLOTS    = 4,
  parameter int ADDR_W   = 32,
  parameter int DATA_W   = 32
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  ctlStrobe_t                strobe,
  input  logic [THREAD_W-1:0]       rptThread,
  input  logic                      rptQualified,
  input  logic [SLOTS*THREAD_W-1:0] svIn,
  input  logic [SLOTS-1:0]          svValidIn,
  input  logic [ADDR_W-1:0]         cfgBase,
  input  logic [THREAD_W:0]         cfgDim,
  input  logic [DATA_W-1:0]         memRspData,
  output dpStatus_t                 status,
  output logic [ADDR_W-1:0]         memReqAddr,
  output logic [DATA_W-1:0]         memReqWdata,
  output logic [SLOTS*THREAD_W-1:0] svOut,
  output logic [SLOTS-1:0]          svValidOut
);
  localparam int IDX_W  = (SLOTS > 1) ? $clog2(SLOTS) : 1;
  localparam int DIM_W  = THREAD_W + 1;
  localparam int PROD_W = THREAD_W + DIM_W + 1;

  logic [THREAD_W-1:0] curThread;
  logic                curQual;
  logic [THREAD_W-1:0] curSv [SLOTS];
  logic [SLOTS-1:0]    curValid;
  logic [IDX_W-1:0]    idx;
  logic [DATA_W-1:0]   rdWord;

  logic [THREAD_W-1:0] shiftSv [SLOTS];
  logic [SLOTS-1:0]    shiftValid;
  logic [THREAD_W-1:0] curColumn;
  logic [PROD_W-1:0]   elemIdx;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      curThread <= '0;
      curQual   <= 1'b0;
      curValid  <= '0;
      idx       <= '0;
      rdWord    <= '0;
    end else begin
      if (strobe.load) begin
        curThread <= rptThread;
        curQual   <= rptQualified;
        curValid  <= svValidIn;
        idx       <= '0;
      end else if (strobe.advance) begin
        idx <= idx + 1'b1;
      end
      if (strobe.capRd) rdWord <= memRspData;
    end
  end

  for (genvar k = 0; k < SLOTS; k++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rstN) curSv[k] <= '0;
      else if (strobe.load) curSv[k] <= svIn[k*THREAD_W +: THREAD_W];
    end
    if (k == 0) begin : g_head
      assign shiftSv[k]    = curThread;
      assign shiftValid[k] = 1'b1;
    end else begin : g_tail
      assign shiftSv[k]    = curSv[k-1];
      assign shiftValid[k] = curValid[k-1];
    end
    assign svOut[k*THREAD_W +: THREAD_W] = curQual ? shiftSv[k] : curSv[k];
  end

  assign svValidOut = curQual ? shiftValid : curValid;

  assign curColumn       = curSv[idx];
  assign status.eligible = curValid[idx] && (curColumn != curThread);
  assign status.lastSlot = (idx == IDX_W'(SLOTS - 1));

  assign elemIdx     = PROD_W'(curThread) * PROD_W'(cfgDim) + PROD_W'(curColumn);
  assign memReqAddr  = cfgBase + (ADDR_W'(elemIdx) << 2);
  assign memReqWdata = (&rdWord) ? rdWord : rdWord + 1'b1;
endmodule

// File: rtl/smu_control.sv
module smu_control
  import smu_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       rptValid,
  input  logic       rptQualified,
  input  logic       memReqReady,
  input  logic       memRspValid,
  input  dpStatus_t  status,
  output ctlStrobe_t strobe,
  output logic       rptReady,
  output logic       memReqValid,
  output logic       memReqWrite,
  output logic       svOutValid
);
  ctlState_t state, nextState;

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nextState;
  end

  always_comb begin
    nextState   = state;
    strobe      = '0;
    rptReady    = 1'b0;
    memReqValid = 1'b0;
    memReqWrite = 1'b0;
    svOutValid  = 1'b0;
    unique case (state)
      ST_IDLE: begin
        rptReady = 1'b1;
        if (rptValid) begin
          strobe.load = 1'b1;
          nextState   = rptQualified ? ST_SCAN : ST_WB;
        end
      end
      ST_SCAN: begin
        if (status.eligible) nextState = ST_RD_REQ;
        else if (status.lastSlot) nextState = ST_WB;
        else strobe.advance = 1'b1;
      end
      ST_RD_REQ: begin
        memReqValid = 1'b1;
        if (memReqReady) nextState = ST_RD_WAIT;
      end
      ST_RD_WAIT: begin
        if (memRspValid) begin
          strobe.capRd = 1'b1;
          nextState    = ST_WR_REQ;
        end
      end
      ST_WR_REQ: begin
        memReqValid = 1'b1;
        memReqWrite = 1'b1;
        if (memReqReady) begin
          if (status.lastSlot) nextState = ST_WB;
          else begin
            strobe.advance = 1'b1;
            nextState      = ST_SCAN;
          end
        end
      end
      ST_WB: begin
        svOutValid = 1'b1;
        nextState  = ST_IDLE;
      end
      default: nextState = ST_IDLE;
    endcase
  end
endmodule

// File: rtl/sharer_matrix_upd.sv
module sharer_matrix_upd
  import smu_pkg::*;
#(
  parameter int THREAD_W = 6,
  parameter int SLOTS    = 4,
  parameter int ADDR_W   = 32,
  parameter int DATA_W   = 32
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      rptValid,
  output logic                      rptReady,
  input  logic [THREAD_W-1:0]       rptThread,
  input  logic                      rptQualified,
  input  logic [SLOTS*THREAD_W-1:0] svIn,
  input  logic [SLOTS-1:0]          svValidIn,
  input  logic [ADDR_W-1:0]         cfgBase,
  input  logic [THREAD_W:0]         cfgDim,
  output logic                      memReqValid,
  input  logic                      memReqReady,
  output logic                      memReqWrite,
  output logic [ADDR_W-1:0]         memReqAddr,
  output logic [DATA_W-1:0]         memReqWdata,
  input  logic                      memRspValid,
  input  logic [DATA_W-1:0]         memRspData,
  output logic                      svOutValid,
  output logic [SLOTS*THREAD_W-1:0] svOut,
  output logic [SLOTS-1:0]          svValidOut
);
  ctlStrobe_t strobe;
  dpStatus_t  status;

  smu_control ctl_i (
    .clk(clk), .rstN(rstN), .rptValid(rptValid), .rptQualified(rptQualified),
    .memReqReady(memReqReady), .memRspValid(memRspValid), .status(status),
    .strobe(strobe), .rptReady(rptReady), .memReqValid(memReqValid),
    .memReqWrite(memReqWrite), .svOutValid(svOutValid)
  );

  smu_datapath #(.THREAD_W(THREAD_W), .SLOTS(SLOTS), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) dp_i (
    .clk(clk), .rstN(rstN), .strobe(strobe), .rptThread(rptThread),
    .rptQualified(rptQualified), .svIn(svIn), .svValidIn(svValidIn),
    .cfgBase(cfgBase), .cfgDim(cfgDim), .memRspData(memRspData), .status(status),
    .memReqAddr(memReqAddr), .memReqWdata(memReqWdata), .svOut(svOut),
    .svValidOut(svValidOut)
  );
endmodule

// File: rtl/smu_checker.sv
module smu_checker #(
  parameter int THREAD_W = 6,
  parameter int SLOTS    = 4,
  parameter int ADDR_W   = 32,
  parameter int DATA_W   = 32
) (
  input logic                      clk,
  input logic                      rstN,
  input logic                      rptValid,
  input logic                      rptReady,
  input logic [THREAD_W-1:0]       rptThread,
  input logic                      rptQualified,
  input logic [SLOTS*THREAD_W-1:0] svIn,
  input logic [SLOTS-1:0]          svValidIn,
  input logic [ADDR_W-1:0]         cfgBase,
  input logic [THREAD_W:0]         cfgDim,
  input logic                      memReqValid,
  input logic                      memReqReady,
  input logic                      memReqWrite,
  input logic [ADDR_W-1:0]         memReqAddr,
  input logic [DATA_W-1:0]         memReqWdata,
  input logic                      memRspValid,
  input logic [DATA_W-1:0]         memRspData,
  input logic                      svOutValid,
  input logic [SLOTS*THREAD_W-1:0] svOut,
  input logic [SLOTS-1:0]          svValidOut
);
  logic [THREAD_W-1:0]       latT;
  logic                      latQual;
  logic [SLOTS*THREAD_W-1:0] latSv;
  logic [SLOTS-1:0]          latValid;
  logic [DATA_W-1:0]         rspWord;
  logic [ADDR_W-1:0]         offset, wordOff, rowLo, rowHi;
  logic                      inRow;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      latT <= '0; latQual <= 1'b0; latSv <= '0; latValid <= '0; rspWord <= '0;
    end else begin
      if (rptValid && rptReady) begin
        latT <= rptThread; latQual <= rptQualified; latSv <= svIn; latValid <= svValidIn;
      end
      if (memRspValid) rspWord <= memRspData;
    end
  end

  always_comb begin
    offset  = memReqAddr - cfgBase;
    wordOff = offset >> 2;
    rowLo   = ADDR_W'(latT) * ADDR_W'(cfgDim);
    rowHi   = rowLo + ADDR_W'(cfgDim);
    inRow   = (offset[1:0] == 2'b00) && (wordOff >= rowLo) && (wordOff < rowHi);
  end

  AST_UNQUAL_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !latQual |-> !memReqValid); // R1
  AST_ROW_ONLY: assert property (@(posedge clk) disable iff (!rstN)
    memReqValid |-> inRow); // R3
  AST_SAT_INC: assert property (@(posedge clk) disable iff (!rstN)
    (memReqValid && memReqWrite) |-> memReqWdata == ((&rspWord) ? rspWord : rspWord + 1'b1)); // R4
  AST_WB_SHIFT: assert property (@(posedge clk) disable iff (!rstN)
    (svOutValid && latQual) |-> (svOut[THREAD_W-1:0] == latT) && svValidOut[0]
      && (svOut[SLOTS*THREAD_W-1:THREAD_W] == latSv[(SLOTS-1)*THREAD_W-1:0])); // R5
  AST_WB_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    svOutValid |=> !svOutValid); // R5
  AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rstN)
    (memReqValid || svOutValid) |-> !rptReady); // R7
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (memReqValid && !memReqReady) |=> memReqValid && $stable(memReqAddr)
      && $stable(memReqWrite) && $stable(memReqWdata)); // R8
endmodule

bind sharer_matrix_upd smu_checker #(
  .THREAD_W(THREAD_W), .SLOTS(SLOTS), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
) chk_i (.*);

// File: tb/sharer_matrix_upd_tb_top.sv
module sharer_matrix_upd_tb_top;
  localparam int THREAD_W = 3;
  localparam int SLOTS    = 4;
  localparam int ADDR_W   = 32;
  localparam int DATA_W   = 32;
  localparam int DIM      = 8;
  localparam int WORDS    = DIM * DIM;
  localparam logic [ADDR_W-1:0] BASE = 32'h0000_4000;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic rptValid = 1'b0;
  logic rptReady;
  logic [THREAD_W-1:0] rptThread = '0;
  logic rptQualified = 1'b0;
  logic [SLOTS*THREAD_W-1:0] svIn = '0;
  logic [SLOTS-1:0] svValidIn = '0;
  logic [ADDR_W-1:0] cfgBase = BASE;
  logic [THREAD_W:0] cfgDim = (THREAD_W+1)'(DIM);
  logic memReqValid, memReqWrite;
  logic memReqReady;
  logic [ADDR_W-1:0] memReqAddr;
  logic [DATA_W-1:0] memReqWdata;
  logic memRspValid;
  logic [DATA_W-1:0] memRspData;
  logic svOutValid;
  logic [SLOTS*THREAD_W-1:0] svOut;
  logic [SLOTS-1:0] svValidOut;

  always #10 clk = ~clk;

  sharer_matrix_upd #(.THREAD_W(THREAD_W), .SLOTS(SLOTS), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) dut_i (
    .clk(clk), .rstN(rstN), .rptValid(rptValid), .rptReady(rptReady),
    .rptThread(rptThread), .rptQualified(rptQualified), .svIn(svIn),
    .svValidIn(svValidIn), .cfgBase(cfgBase), .cfgDim(cfgDim),
    .memReqValid(memReqValid), .memReqReady(memReqReady), .memReqWrite(memReqWrite),
    .memReqAddr(memReqAddr), .memReqWdata(memReqWdata), .memRspValid(memRspValid),
    .memRspData(memRspData), .svOutValid(svOutValid), .svOut(svOut),
    .svValidOut(svValidOut)
  );

  int checks = 0;
  int fails  = 0;
  int badAddr = 0;

  // memory model
  logic [DATA_W-1:0] mem [WORDS];
  logic [DATA_W-1:0] expMem [WORDS];
  int wrLog[$];
  int pendCnt;
  int pendIdx;
  logic pokeEn = 1'b0;
  int pokeIdx = 0;
  logic [DATA_W-1:0] pokeVal = '0;

  always @(posedge clk) begin
    if (!rstN) begin
      memReqReady <= 1'b0;
      memRspValid <= 1'b0;
      memRspData  <= '0;
      pendCnt     <= 0;
      pendIdx     <= 0;
      for (int i = 0; i < WORDS; i++) mem[i] <= '0;
    end else begin
      memReqReady <= (($urandom % 4) != 0);
      memRspValid <= 1'b0;
      if (pokeEn) mem[pokeIdx] <= pokeVal;
      if (memReqValid && memReqReady) begin
        automatic logic [ADDR_W-1:0] off = memReqAddr - BASE;
        automatic int w = int'(off >> 2);
        if (off[1:0] != 2'b00 || off >= ADDR_W'(WORDS * 4)) begin
          badAddr <= badAddr + 1;
        end else if (memReqWrite) begin
          mem[w] <= memReqWdata;
          wrLog.push_back(w);
        end else begin
          pendCnt <= 1 + int'($urandom % 3);
          pendIdx <= w;
        end
      end
      if (pendCnt != 0) begin
        pendCnt <= pendCnt - 1;
        if (pendCnt == 1) begin
          memRspValid <= 1'b1;
          memRspData  <= mem[pendIdx];
        end
      end
    end
  end

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic poke(input int idx, input logic [DATA_W-1:0] val);
    @(negedge clk);
    pokeEn = 1'b1; pokeIdx = idx; pokeVal = val;
    @(negedge clk);
    pokeEn = 1'b0;
    expMem[idx] = val;
  endtask

  task automatic runReport(input logic [THREAD_W-1:0] t, input bit qual,
                           input logic [SLOTS*THREAD_W-1:0] sv, input logic [SLOTS-1:0] vld);
    int expList[$];
    logic [SLOTS*THREAD_W-1:0] expSv;
    logic [SLOTS-1:0] expVld;
    bit seen;
    bit mismatch;
    // expected model from R1..R6
    for (int i = 0; i < SLOTS; i++) begin
      automatic logic [THREAD_W-1:0] c = sv[i*THREAD_W +: THREAD_W];
      if (qual && vld[i] && c != t) begin
        automatic int w = int'(t) * DIM + int'(c);
        expList.push_back(w);
        if (expMem[w] != 32'hFFFF_FFFF) expMem[w] = expMem[w] + 1;
      end
    end
    if (qual) begin
      expSv  = {sv[(SLOTS-1)*THREAD_W-1:0], t};
      expVld = {vld[SLOTS-2:0], 1'b1};
    end else begin
      expSv = sv; expVld = vld;
    end
    @(negedge clk);
    while (!rptReady) @(negedge clk);
    wrLog.delete();
    rptValid = 1'b1; rptThread = t; rptQualified = qual; svIn = sv; svValidIn = vld;
    @(negedge clk);
    rptValid = 1'b0;
    check(rptReady == 1'b0, "R7 busy after accept", rptReady, 0);
    seen = 0;
    for (int n = 0; n < 400 && !seen; n++) begin
      if (svOutValid) seen = 1;
      else @(negedge clk);
    end
    check(seen, "R5 writeback seen", seen, 1);
    if (seen) begin
      check(svOut == expSv, qual ? "R5 shifted vector" : "R1 vector unchanged", svOut, expSv);
      check(svValidOut == expVld, qual ? "R5 shifted valid" : "R1 valid unchanged", svValidOut, expVld);
      @(negedge clk);
      check(svOutValid == 1'b0, "R5 one-cycle pulse", svOutValid, 0);
    end
    mismatch = (wrLog.size() != expList.size());
    for (int i = 0; i < expList.size() && !mismatch; i++)
      if (wrLog[i] != expList[i]) mismatch = 1;
    check(!mismatch, qual ? "R2/R3/R6 write sequence" : "R1 no writes",
          wrLog.size(), expList.size());
    mismatch = 0;
    for (int i = 0; i < WORDS; i++) if (mem[i] != expMem[i]) mismatch = 1;
    check(!mismatch, "R4 matrix contents", mismatch, 0);
    check(badAddr == 0, "R3 address in matrix", badAddr, 0);
  endtask

  function automatic logic [SLOTS*THREAD_W-1:0] packSv(input int a, b, c, d);
    return {THREAD_W'(d), THREAD_W'(c), THREAD_W'(b), THREAD_W'(a)};
  endfunction

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < WORDS; i++) expMem[i] = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R9 reset state
    check(rptReady == 1'b1, "R9 ready after reset", rptReady, 1);
    check(memReqValid == 1'b0, "R9 no request after reset", memReqValid, 0);
    check(svOutValid == 1'b0, "R9 no writeback after reset", svOutValid, 0);

    // R1 unqualified with full vector
    runReport(3'd2, 1'b0, packSv(1, 4, 5, 6), 4'b1111);
    // R6 all slots empty
    runReport(3'd1, 1'b1, packSv(2, 3, 4, 5), 4'b0000);
    // R6 all slots equal T
    runReport(3'd5, 1'b1, packSv(5, 5, 5, 5), 4'b1111);
    // R2 duplicates and order, oldest dropped
    runReport(3'd0, 1'b1, packSv(7, 3, 7, 1), 4'b1111);
    // R4 saturation at all ones
    poke(6 * DIM + 3, 32'hFFFF_FFFE);
    runReport(3'd6, 1'b1, packSv(3, 0, 0, 0), 4'b0001);
    runReport(3'd6, 1'b1, packSv(3, 0, 0, 0), 4'b0001);
    check(mem[6 * DIM + 3] == 32'hFFFF_FFFF, "R4 saturated word", mem[6 * DIM + 3], 32'hFFFF_FFFF);

    // random mix
    for (int r = 0; r < 60; r++) begin
      automatic logic [THREAD_W-1:0] t = THREAD_W'($urandom);
      automatic bit q = (($urandom % 5) != 0);
      automatic logic [SLOTS*THREAD_W-1:0] sv = (SLOTS*THREAD_W)'($urandom);
      automatic logic [SLOTS-1:0] v = SLOTS'($urandom);
      runReport(t, q, sv, v);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule